// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns serial audio on a bit clock and a frame clock into parallel samples. In the normal modes it listens to three data lines at once, and each line carries one stereo pair. In time-division mode it takes all six channels from the first line alone. It handles four two-channel framings: right-justified, left-justified, I2S and a short-pulse DSP framing. It also handles a six-channel TDM framing with a frame-sync pulse. Word length can be 16, 20 or 24 bits.

The serial inputs are treated as synchronous to the block clock `clk`, which must run at least four times faster than the bit clock. The block finds the bit-clock edges itself. Each finished word comes out as a 24-bit left-aligned sample together with a channel index and a one-cycle valid strobe. When several lines finish a word at the same moment, their samples come out on consecutive cycles. `fmt_i` and `wlen_i` may only change while reset is held.

Top module: `asr_rx`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `valid_o` is 0, and `sample_o` and `chan_o` read zero.
- R2: Left-justified (`fmt_i`=1). The bit sampled on the bit-clock rising edge at which the frame clock is first seen at a new level is the MSB. Frame clock low selects the left channel and high selects the right channel.
- R3: I2S (`fmt_i`=2). The MSB is the bit sampled one bit clock after the edge at which the frame-clock change is seen. Low means left and high means right.
- R4: Right-justified (`fmt_i`=0). The LSB is the last bit sampled before the frame clock changes. The word is reported at that change and takes the side of the level that just ended. A frame-clock change is reported only if an earlier change has been seen since reset.
- R5: DSP (`fmt_i`=3). A frame-clock high lasting one bit clock marks the frame start. The left MSB is the next bit, and the right word follows the left LSB with no gap.
- R6: TDM (`fmt_i`=4). The frame-sync and the data are sampled on bit-clock falling edges, and the bit sampled with frame-sync high is bit 0 of the frame. The frame has eight 32-bit slots, and slot s (s=0..5) gives channel s MSB-first from the start of the slot. Slots 6 and 7 and data lines 1 and 2 produce no output.
- R7: `wlen_i` selects 16 (0), 20 (1) or 24 (2) bits. Data arrives MSB first in two's complement. Shorter words leave the block in bits 23 down, with zeros below.
- R8: Channel index for normal modes: line k, side s (0 left, 1 right) gives channel 2k+s. At most one sample is presented per cycle. Samples finishing together come out on consecutive cycles, in ascending line order.
- R9: After reset, the first active bit-clock edge only records the frame-clock level. No sample is produced before the first frame start that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_i | input | 3 | Framing: 0 RJ, 1 LJ, 2 I2S, 3 DSP, 4 TDM |
| wlen_i | input | 2 | Word length: 0=16, 1=20, 2=24 bits |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame clock or frame-sync pulse |
| sdin_i | input | 3 | Serial data lines, bit k = line k |
| sample_o | output | 24 | Left-aligned received sample |
| chan_o | output | 3 | Channel index 0..5 |
| valid_o | output | 1 | One-cycle strobe for sample_o/chan_o |

## Verification
The hardest behaviour to reach is the right-justified report. It happens only at the frame-clock change after a word ends, and only once an earlier change has been seen. For this reason every run begins with a few bits at one frame-clock level before the first frame and ends with a short tail that supplies the closing change. Every bit outside a word is driven to 1, including the unused TDM slots, TDM lines 1 and 2, and the I2S delay bit. Any misplaced capture window or missing zero-fill therefore shows up as corrupted samples or extra samples. The bench sweeps every framing against every word length, and the expected samples come from a fixed arithmetic pattern.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
// Shared constants, framing encoding and word-alignment helpers for the
// audio serial receiver.
package asr_pkg;
    localparam int SAMPLE_W   = 24;   // output sample width
    localparam int LANES      = 3;    // serial data lines
    localparam int POS_W      = 9;    // bit position counter width
    localparam int SLOT_BITS  = 5;    // log2 of TDM slot length (32)
    localparam int SLOT_IDX_W = 3;    // log2 of TDM slots per frame (8)
    localparam int SLOTS_USED = 6;    // TDM slots that carry channels
    localparam int CHAN_W     = 3;    // channel index width

    typedef enum logic [2:0] {
        FMT_RJ  = 3'd0,
        FMT_LJ  = 3'd1,
        FMT_I2S = 3'd2,
        FMT_DSP = 3'd3,
        FMT_TDM = 3'd4
    } fmt_e;

    // Number of bits in a word for a word-length code.
    function automatic logic [POS_W-1:0] word_bits(input logic [1:0] wl);
        case (wl)
            2'd0:    return POS_W'(16);
            2'd1:    return POS_W'(20);
            default: return POS_W'(24);
        endcase
    endfunction

    // Move the newest word_bits(wl) bits to the top, zero-filling below.
    function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] raw,
                                                       input logic [1:0] wl);
        case (wl)
            2'd0:    return {raw[15:0], 8'h00};
            2'd1:    return {raw[19:0], 4'h0};
            default: return raw;
        endcase
    endfunction
endpackage

// File: rtl/asr_timing.sv
`timescale 1ns/1ps
// Bit-clock edge finder and frame-position tracker.
// Assumes bclk/lrclk are synchronous to clk and each bit-clock level lasts
// at least two clk cycles. The active edge is the rising edge in normal
// modes and the falling edge in TDM. The first active edge after reset only
// records the frame-clock level. pos is the bit index of the current active
// edge counted from the last frame start, and it saturates.
module asr_timing
    import asr_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tdm,
    input  logic          pulse_mode,
    input  logic          bclk,
    input  logic          lrclk,
    output logic          act,
    output logic          start,
    output logic [PW-1:0] pos,
    output logic          armed,
    output logic          lr_last
);
    localparam logic [PW-1:0] POS_MAX = '1;

    logic          bclk_q, seen_q, lr_q, armed_q;
    logic [PW-1:0] pos_q;
    logic          level_chg, pulse_hit;

    // Find the active edge and the frame start, and advance the position.
    always_comb begin
        act       = tdm ? (bclk_q & ~bclk) : (~bclk_q & bclk);
        level_chg = seen_q & (lrclk ^ lr_q);
        pulse_hit = seen_q & lrclk & ~lr_q;
        start     = act & (pulse_mode ? pulse_hit : level_chg);
        if (start)
            pos = '0;
        else if (pos_q == POS_MAX)
            pos = POS_MAX;
        else
            pos = pos_q + 1'b1;
    end

    // Keep the bit-clock history, the last frame-clock level and the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            seen_q  <= 1'b0;
            lr_q    <= 1'b0;
            armed_q <= 1'b0;
            pos_q   <= POS_MAX;
        end else begin
            bclk_q <= bclk;
            if (act) begin
                seen_q <= 1'b1;
                lr_q   <= lrclk;
                pos_q  <= pos;
                if (start)
                    armed_q <= 1'b1;
            end
        end
    end

    assign armed   = armed_q;
    assign lr_last = lr_q;
endmodule

// File: rtl/asr_lane.sv
`timescale 1ns/1ps
// One serial data line: a 24-bit shift register filled MSB first on each
// active edge. It offers two aligned views: the word that includes the
// current bit, and the word as it stood before the current bit.
module asr_lane
    import asr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift,
    input  logic                sd,
    input  logic [1:0]          wl,
    output logic [SAMPLE_W-1:0] word_new,
    output logic [SAMPLE_W-1:0] word_old
);
    logic [SAMPLE_W-1:0] sr_q, sr_nxt;

    // Form the next contents and both aligned views.
    always_comb begin
        sr_nxt   = {sr_q[SAMPLE_W-2:0], sd};
        word_new = left_align(sr_nxt, wl);
        word_old = left_align(sr_q, wl);
    end

    // Shift in one bit per active edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift)
            sr_q <= sr_nxt;
    end
endmodule

// File: rtl/asr_out_seq.sv
`timescale 1ns/1ps
// Output sequencer. Holds the words captured together and presents one per
// cycle, lowest line first. Assumes captures are spaced further apart than
// N clk cycles, which holds whenever words are many bit clocks apart.
module asr_out_seq
    import asr_pkg::*;
#(
    parameter int N = LANES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [N-1:0]                 mask,
    input  logic [N-1:0][SAMPLE_W-1:0]   words,
    input  logic [N-1:0][CHAN_W-1:0]     chans,
    output logic [SAMPLE_W-1:0]          sample_o,
    output logic [CHAN_W-1:0]            chan_o,
    output logic                         valid_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]               pend_q, sel;
    logic [N-1:0][SAMPLE_W-1:0] hold_w;
    logic [N-1:0][CHAN_W-1:0]   hold_c;
    logic [IDX_W-1:0]           idx;

    // Pick the lowest pending line.
    always_comb begin
        sel = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end

    // Load new captures and present one held word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            hold_w   <= '0;
            hold_c   <= '0;
            sample_o <= '0;
            chan_o   <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= |pend_q;
            if (|pend_q) begin
                sample_o <= hold_w[idx];
                chan_o   <= hold_c[idx];
            end
            pend_q <= (pend_q & ~sel) | (load ? mask : '0);
            for (int k = 0; k < N; k++) begin
                if (load && mask[k]) begin
                    hold_w[k] <= words[k];
                    hold_c[k] <= chans[k];
                end
            end
        end
    end
endmodule

// File: rtl/asr_rx.sv
`timescale 1ns/1ps
// Multi-format audio serial receiver, top level.
// Decodes RJ, LJ, I2S, DSP and TDM framing with 16/20/24-bit words and
// emits left-aligned samples tagged with a channel index. Assumes fmt_i and
// wlen_i change only under reset, and that each normal-mode half frame holds
// at least word length + 1 bits.
module asr_rx
    import asr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic [LANES-1:0]    sdin_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic [CHAN_W-1:0]   chan_o,
    output logic                valid_o
);
    localparam logic [POS_W-1:0] TDM_FRAME = POS_W'((1 << SLOT_IDX_W) << SLOT_BITS);

    fmt_e                           fmt;
    logic                           is_tdm, pulse_mode;
    logic                           act, start, armed, lr_last;
    logic [POS_W-1:0]               pos, wlen_pos;
    logic [SLOT_IDX_W-1:0]          slot;
    logic                           cap, use_old, side;
    logic [LANES-1:0]               mask;
    logic [LANES-1:0][SAMPLE_W-1:0] w_new, w_old, words;
    logic [LANES-1:0][CHAN_W-1:0]   chans;

    assign fmt        = fmt_e'(fmt_i);
    assign is_tdm     = (fmt == FMT_TDM);
    assign pulse_mode = (fmt == FMT_DSP) || (fmt == FMT_TDM);
    assign wlen_pos   = word_bits(wlen_i);
    assign slot       = pos[SLOT_BITS +: SLOT_IDX_W];

    asr_timing #(.PW(POS_W)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .tdm        (is_tdm),
        .pulse_mode (pulse_mode),
        .bclk       (bclk_i),
        .lrclk      (lrclk_i),
        .act        (act),
        .start      (start),
        .pos        (pos),
        .armed      (armed),
        .lr_last    (lr_last)
    );

    // Decide when a word is complete, its side, and where it is taken from.
    always_comb begin
        cap     = 1'b0;
        use_old = 1'b0;
        side    = lrclk_i;
        mask    = '1;
        case (fmt)
            FMT_LJ:  cap = act && (pos == wlen_pos - 1'b1);
            FMT_I2S: cap = act && (pos == wlen_pos);
            FMT_RJ: begin
                cap     = start && armed;
                side    = lr_last;
                use_old = 1'b1;
            end
            FMT_DSP: begin
                cap  = act && ((pos == wlen_pos) || (pos == (wlen_pos << 1)));
                side = (pos == (wlen_pos << 1));
            end
            FMT_TDM: begin
                cap  = act && (pos < TDM_FRAME)
                           && (pos[SLOT_BITS-1:0] == SLOT_BITS'(wlen_pos - 1'b1))
                           && (slot < SLOT_IDX_W'(SLOTS_USED));
                mask = LANES'(1);
            end
            default: cap = 1'b0;
        endcase
    end

    // One shift register per data line, with its word and channel selection.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        asr_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift    (act),
            .sd       (sdin_i[k]),
            .wl       (wlen_i),
            .word_new (w_new[k]),
            .word_old (w_old[k])
        );
        assign words[k] = use_old ? w_old[k] : w_new[k];
        assign chans[k] = is_tdm ? CHAN_W'(slot)
                                 : CHAN_W'(2 * k) + CHAN_W'(side);
    end

    asr_out_seq #(.N(LANES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cap),
        .mask     (mask),
        .words    (words),
        .chans    (chans),
        .sample_o (sample_o),
        .chan_o   (chan_o),
        .valid_o  (valid_o)
    );
endmodule

// File: rtl/asr_rx_chk.sv
`timescale 1ns/1ps
// Property checker for asr_rx, attached through bind. It watches the ports only.
module asr_rx_chk
    import asr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          wlen_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic [CHAN_W-1:0]   chan_o,
    input logic                valid_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!valid_o && sample_o == '0 && chan_o == '0));

    // R8
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (chan_o < CHAN_W'(6)));

    // R8
    burst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (chan_o > $past(chan_o)));

    // R8
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && $past(valid_o) && $past(valid_o, 2) && $past(valid_o, 3)));

    // R7
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((wlen_i == 2'd0) ? (sample_o[7:0] == 8'h00)
                   : (wlen_i == 2'd1) ? (sample_o[3:0] == 4'h0) : 1'b1));
endmodule

bind asr_rx asr_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wlen_i   (wlen_i),
    .sample_o (sample_o),
    .chan_o   (chan_o),
    .valid_o  (valid_o)
);

// File: tb/asr_rx_tb.sv
`timescale 1ns/1ps
// Sweeps every framing against every word length: two frames each, every
// filler bit driven to 1, expected samples from an arithmetic pattern.
module asr_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic [1:0]  wlen = 2'd0;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic [2:0]  sdin = 3'b000;
    logic [23:0] sample_o;
    logic [2:0]  chan_o;
    logic        valid_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [23:0] rec_s [0:63];
    logic [2:0]  rec_c [0:63];
    int          rec_n = 0;
    bit          rec_clr = 1'b0;

    always #4 clk = ~clk;

    asr_rx u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_i    (fmt),
        .wlen_i   (wlen),
        .bclk_i   (bclk),
        .lrclk_i  (lrclk),
        .sdin_i   (sdin),
        .sample_o (sample_o),
        .chan_o   (chan_o),
        .valid_o  (valid_o)
    );

    // Record every presented sample, away from the active edge.
    always @(negedge clk) begin
        if (rec_clr)
            rec_n = 0;
        else if (valid_o && rec_n < 64) begin
            rec_s[rec_n] = sample_o;
            rec_c[rec_n] = chan_o;
            rec_n = rec_n + 1;
        end
    end

    function automatic logic [23:0] pat(int f, int ch, int m, int wl);
        return 24'hA53C96 ^ 24'(ch * 127301 + f * 439361 + m * 45 + wl * 113);
    endfunction

    function automatic int wbits(int wl);
        return (wl == 0) ? 16 : (wl == 1) ? 20 : 24;
    endfunction

    // One bit: data changes at the idle bit-clock level, then the active edge.
    task automatic put_bit(input logic lr, input logic [2:0] d);
        logic idle;
        idle = (fmt == 3'd4);
        @(negedge clk);
        bclk = idle; lrclk = lr; sdin = d;
        repeat (2) @(negedge clk);
        bclk = ~idle;
        @(negedge clk);
    endtask

    // Return bit b of a normal-mode half for a word v of length w.
    function automatic logic half_bit(int m, int w, int b, logic [23:0] v);
        if (m == 1) return (b < w) ? v[w-1-b] : 1'b1;
        if (m == 2) return (b >= 1 && b <= w) ? v[w-b] : 1'b1;
        return (b >= 32 - w) ? v[31-b] : 1'b1;
    endfunction

    task automatic run_case(input int m, input int wl, input string req);
        int w;
        logic [2:0] d;
        int order [0:5];
        w = wbits(wl);
        rst_n = 1'b0; fmt = 3'(m); wlen = 2'(wl);
        bclk = (m == 4); lrclk = 1'b0; sdin = '0;
        rec_clr = 1'b1;
        repeat (3) @(negedge clk);
        rec_clr = 1'b0;
        rst_n = 1'b1;
        // preamble: establishes the level, no frame start
        for (int i = 0; i < 3; i++) put_bit((m <= 2) ? 1'b1 : 1'b0, 3'b111);
        for (int f = 0; f < 2; f++) begin
            if (m <= 2) begin
                for (int h = 0; h < 2; h++)
                    for (int b = 0; b < 32; b++) begin
                        for (int k = 0; k < 3; k++)
                            d[k] = half_bit(m, w, b, pat(f, 2*k + h, m, wl));
                        put_bit(1'(h), d);
                    end
            end else if (m == 3) begin
                for (int b = 0; b < 64; b++) begin
                    for (int k = 0; k < 3; k++) begin
                        if (b >= 1 && b <= w)
                            d[k] = pat(f, 2*k, m, wl)[w-b];
                        else if (b > w && b <= 2*w)
                            d[k] = pat(f, 2*k + 1, m, wl)[2*w-b];
                        else
                            d[k] = 1'b1;
                    end
                    put_bit(b == 0, d);
                end
            end else begin
                for (int b = 0; b < 256; b++) begin
                    d = 3'b111;
                    if ((b / 32) < 6 && (b % 32) < w)
                        d[0] = pat(f, b / 32, m, wl)[w-1-(b%32)];
                    put_bit(b == 0, d);
                end
            end
        end
        // tail: supplies the closing frame-clock change for RJ
        for (int i = 0; i < 2; i++) put_bit(1'b0, 3'b111);
        repeat (10) @(negedge clk);

        if (m == 4) begin
            for (int i = 0; i < 6; i++) order[i] = i;
        end else begin
            order[0] = 0; order[1] = 2; order[2] = 4;
            order[3] = 1; order[4] = 3; order[5] = 5;
        end
        // R9 and mode rule: exactly twelve samples, none from preamble or ignored data
        tests++;
        if (rec_n != 12) begin
            fails++;
            $display("FAIL %s,R9 fmt=%0d wl=%0d: got %0d samples, expected 12", req, m, wl, rec_n);
        end
        for (int i = 0; i < 12 && i < rec_n; i++) begin
            logic [23:0] e;
            logic [2:0]  ec;
            ec = 3'(order[i % 6]);
            e  = pat(i / 6, order[i % 6], m, wl) << (24 - w);
            if (w < 24) e = e & ~(24'hFFFFFF >> w);
            tests++;
            if (rec_s[i] !== e || rec_c[i] !== ec) begin
                fails++;
                $display("FAIL %s,R7,R8 fmt=%0d wl=%0d idx=%0d: got chan=%0d sample=%h, expected chan=%0d sample=%h",
                         req, m, wl, i, rec_c[i], rec_s[i], ec, e);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        tests++;
        if (valid_o !== 1'b0 || sample_o !== 24'h0 || chan_o !== 3'd0) begin
            fails++;
            $display("FAIL R1: got valid=%b sample=%h chan=%0d, expected 0 0 0", valid_o, sample_o, chan_o);
        end
        for (int wl = 0; wl < 3; wl++) begin
            run_case(1, wl, "R2");
            run_case(2, wl, "R3");
            run_case(0, wl, "R4");
            run_case(3, wl, "R5");
            run_case(4, wl, "R6");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule